// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block drives and samples a set of general-purpose pins through a small byte-wide register bus. The pins are split at a parameter boundary into two banks, a core bank and a resume bank. Each bank has its own register window. Software uses these windows to claim pins, set direction, drive or read levels and pick which edges to watch. Software also acknowledges captured edge events in the same windows.

Input pins pass through a two-flop synchronizer before they are used. A qualifying edge on a claimed pin latches a status bit. Status bits that are pending and also selected by the event mask are ORed into one level-sensitive interrupt line. The line stays high until software clears the bits by writing ones to them. The status of each bank is also presented as a 32-bit word for a wide read path.

Top module: `gpio_two_bank`

## Requirements
- R1: After reset every register reads zero, except the direction register. Its bits read one (input) for every existing pin. irq and all pin_oe bits are low.
- R2: The byte address selects a bank with bit 5 (0 core, 1 resume), a register with bits 4:2 and a byte with bits 1:0. The register codes are 0 enable, 1 direction, 2 level, 3 rising select, 4 falling select, 5 event mask, 6 reserved (reads zero, writes ignored) and 7 status. A pin's bit is its bank index modulo 8 within byte index/8. Bits with no pin behind them read zero. Reads are combinational.
- R3: Pin p below SPLIT uses core index p. Pin p at or above SPLIT uses resume index p-SPLIT.
- R4: pin_oe of a pin is high when its enable bit is 1 and its direction bit is 0 (output). pin_out carries the level register.
- R5: A level write to a pin whose direction bit is 1 leaves the stored output level unchanged. Reading the level of an input pin returns its synchronized input.
- R6: An input change is captured by two flops. The resulting status bit is visible after the third rising clock edge following the change.
- R7: The rising select alone catches only 0-to-1 edges. The falling select alone catches only 1-to-0 edges. Both selects together catch either edge.
- R8: A status bit sets on a qualifying edge even when its event-mask bit is 0. No edge is captured while the pin's enable bit is 0.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. A new edge in the same cycle as the clear keeps the bit set.
- R10: irq is high exactly while some status bit with its event-mask bit set is pending.
- R11: stat_core and stat_resume present the status bits of each bank, with the pin at bank index i at bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 6 | Byte address (bank, register, byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| stat_core | output | 32 | Core bank status word |
| stat_resume | output | 32 | Resume bank status word |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an edge that arrives in exactly the cycle in which software writes the acknowledge for an already pending bit. The edge must be counted forward through the two synchronizer stages so that it lands on the cycle of the clear. The bench does this by changing the pin and then issuing the clear write on the third clock edge. A second subtle case is a level write made while a pin is an input. The stored value only shows after the pin is turned back into an output, so the bench switches direction around that write. Random bus traffic and pin noise then run against a cycle model in the bench.

// File: rtl/gpio_two_bank.sv
module gpio_two_bank #(
  parameter int NPINS = 14,
  parameter int SPLIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [31:0]      stat_core,
  output logic [31:0]      stat_resume,
  output logic             irq
);
  localparam logic [2:0] R_EN = 3'd0, R_DIR = 3'd1, R_LVL = 3'd2, R_RISE = 3'd3;
  localparam logic [2:0] R_FALL = 3'd4, R_EVT = 3'd5, R_STS = 3'd7;

  logic [NPINS-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, evt_q, sts_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q;
  logic [NPINS-1:0] hit, wbit, set_v, clr_v;
  logic [7:0][NPINS-1:0] regv;
  logic [7:0][31:0] cview, rview;
  logic [2:0] rsel;
  logic [31:0] word;

  assign rsel = bus_addr[4:2];

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      hit[i]  = bus_we && (bus_addr[5] == (i >= SPLIT)) &&
                (32'(bus_addr[1:0]) == (i - ((i >= SPLIT) ? SPLIT : 0)) / 8);
      wbit[i] = bus_wdata[(i - ((i >= SPLIT) ? SPLIT : 0)) % 8];
    end
  end

  assign set_v = en_q & ((rise_q & s2_q & ~s3_q) | (fall_q & ~s2_q & s3_q));
  assign clr_v = (rsel == R_STS) ? (hit & wbit) : '0;

  assign regv[0] = en_q;
  assign regv[1] = dir_q;
  assign regv[2] = (dir_q & s2_q) | (~dir_q & lvl_q);
  assign regv[3] = rise_q;
  assign regv[4] = fall_q;
  assign regv[5] = evt_q;
  assign regv[6] = '0;
  assign regv[7] = sts_q;

  always_comb begin
    cview = '0;
    rview = '0;
    for (int i = 0; i < NPINS; i++)
      for (int r = 0; r < 8; r++)
        if (i < SPLIT) cview[r][i] = regv[r][i];
        else           rview[r][i-SPLIT] = regv[r][i];
  end

  assign word        = bus_addr[5] ? rview[rsel] : cview[rsel];
  assign bus_rdata   = word[{bus_addr[1:0], 3'b000} +: 8];
  assign stat_core   = cview[R_STS];
  assign stat_resume = rview[R_STS];
  assign pin_oe      = en_q & ~dir_q;
  assign pin_out     = lvl_q;
  assign irq         = |(sts_q & evt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; dir_q <= '1; lvl_q <= '0; rise_q <= '0;
      fall_q <= '0; evt_q <= '0; sts_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      sts_q <= set_v | (sts_q & ~clr_v);
      for (int i = 0; i < NPINS; i++) begin
        if (hit[i]) begin
          case (rsel)
            R_EN:   en_q[i]   <= wbit[i];
            R_DIR:  dir_q[i]  <= wbit[i];
            R_LVL:  if (!dir_q[i]) lvl_q[i] <= wbit[i];
            R_RISE: rise_q[i] <= wbit[i];
            R_FALL: fall_q[i] <= wbit[i];
            R_EVT:  evt_q[i]  <= wbit[i];
            default: ;
          endcase
        end
      end
    end
  end

  // R4: a driven pin is never one configured as input
  a_r4_oe_output_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);

  // R8: no status bit rises one cycle after its pin was disabled
  a_r8_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~$past(sts_q) & ~$past(en_q)) == '0);

  // R10: irq can only rise after a new status bit or a new mask bit
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((sts_q & ~$past(sts_q)) != '0) || ((evt_q & ~$past(evt_q)) != '0));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    // R5: stored level holds while the pin is an input
    a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[g] |=> $stable(lvl_q[g]));
    // R9: a captured edge survives a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[g] |=> sts_q[g]);
    // R9: a clear with no edge empties the bit
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[g] && !set_v[g]) |=> !sts_q[g]);
  end
endmodule

// File: tb/sim_gpio_two_bank.sv
`timescale 1ns/1ps
module sim_gpio_two_bank;
  localparam int NP = 14;
  localparam int SP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wd = '0;
  logic [NP-1:0] pins = '0;
  wire  [7:0] rd;
  wire  [NP-1:0] po, poe;
  wire  [31:0] sc, sr;
  wire  irq;
  int total = 0;
  int bad = 0;

  logic [NP-1:0] m_en, m_dir, m_lvl, m_ri, m_fa, m_ev, m_st, m_a, m_b, m_c;

  always #2.5 clk = ~clk;

  gpio_two_bank #(.NPINS(NP), .SPLIT(SP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
    .bus_rdata(rd), .pin_in(pins), .pin_out(po), .pin_oe(poe),
    .stat_core(sc), .stat_resume(sr), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] mread(input logic [5:0] a);
    logic [7:0] v;
    int idx, p, lim;
    v = '0;
    for (int k = 0; k < 8; k++) begin
      idx = int'(a[1:0]) * 8 + k;
      p   = a[5] ? SP + idx : idx;
      lim = a[5] ? NP : SP;
      if (p < lim) begin
        case (a[4:2])
          3'd0: v[k] = m_en[p];
          3'd1: v[k] = m_dir[p];
          3'd2: v[k] = m_dir[p] ? m_b[p] : m_lvl[p];
          3'd3: v[k] = m_ri[p];
          3'd4: v[k] = m_fa[p];
          3'd5: v[k] = m_ev[p];
          3'd7: v[k] = m_st[p];
          default: v[k] = 1'b0;
        endcase
      end
    end
    return v;
  endfunction

  function automatic logic [31:0] mword(input bit bank);
    logic [31:0] w;
    w = '0;
    for (int p = 0; p < NP; p++) begin
      if (!bank && p < SP) w[p] = m_st[p];
      if (bank && p >= SP) w[p-SP] = m_st[p];
    end
    return w;
  endfunction

  task automatic mreset();
    m_en = '0; m_dir = '1; m_lvl = '0; m_ri = '0; m_fa = '0;
    m_ev = '0; m_st = '0; m_a = '0; m_b = '0; m_c = '0;
  endtask

  task automatic mstep();
    logic [NP-1:0] setm, clrm;
    logic [NP-1:0] n_en, n_dir, n_lvl, n_ri, n_fa, n_ev;
    int bank, idx;
    bit b;
    setm = m_en & ((m_ri & m_b & ~m_c) | (m_fa & ~m_b & m_c));
    clrm = '0;
    n_en = m_en; n_dir = m_dir; n_lvl = m_lvl; n_ri = m_ri; n_fa = m_fa; n_ev = m_ev;
    for (int p = 0; p < NP; p++) begin
      bank = (p >= SP) ? 1 : 0;
      idx  = p - bank * SP;
      if (we && int'(addr[5]) == bank && int'(addr[1:0]) == idx / 8) begin
        b = wd[idx % 8];
        case (addr[4:2])
          3'd0: n_en[p] = b;
          3'd1: n_dir[p] = b;
          3'd2: if (!m_dir[p]) n_lvl[p] = b;
          3'd3: n_ri[p] = b;
          3'd4: n_fa[p] = b;
          3'd5: n_ev[p] = b;
          3'd7: clrm[p] = b;
          default: ;
        endcase
      end
    end
    m_st = setm | (m_st & ~clrm);
    m_en = n_en; m_dir = n_dir; m_lvl = n_lvl; m_ri = n_ri; m_fa = n_fa; m_ev = n_ev;
    m_c = m_b; m_b = m_a; m_a = pins;
  endtask

  task automatic cyc(input bit w, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    we = w; addr = a; wd = d;
    #1;
    chk("R2 read data", 32'(rd), 32'(mread(a)));
    chk("R4 output enable", 32'(poe), 32'(m_en & ~m_dir));
    chk("R4 output level", 32'(po), 32'(m_lvl));
    chk("R10 irq", 32'(irq), 32'(|(m_st & m_ev)));
    chk("R11 core word", sc, mword(1'b0));
    chk("R11 resume word", sr, mword(1'b1));
    @(posedge clk);
    mstep();
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 6'h1C, 8'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(1'b0, 6'h04, 8'h00); chk("R1 core dir byte0", 32'(rd), 32'hFF);
    chk("R1 irq low", 32'(irq), 0); chk("R1 oe low", 32'(poe), 0);
    cyc(1'b0, 6'h05, 8'h00); chk("R1 core dir byte1", 32'(rd), 32'h03);
    cyc(1'b0, 6'h24, 8'h00); chk("R1 resume dir byte0", 32'(rd), 32'h0F);
    cyc(1'b0, 6'h25, 8'h00); chk("R2 unimplemented byte", 32'(rd), 32'h00);
    cyc(1'b0, 6'h00, 8'h00); chk("R1 enable zero", 32'(rd), 32'h00);

    // R3 resume pin renumbering
    cyc(1'b1, 6'h20, 8'h01); cyc(1'b1, 6'h24, 8'h0E); cyc(1'b1, 6'h28, 8'h01);
    chk("R3 pin10 out", 32'(po[10]), 1); chk("R3 pin10 oe", 32'(poe[10]), 1);
    chk("R3 pin0 untouched", 32'(po[0]), 0);
    cyc(1'b0, 6'h28, 8'h00); chk("R3 resume level read", 32'(rd), 32'h01);

    // R5 level write ignored on input
    cyc(1'b1, 6'h00, 8'h06); cyc(1'b1, 6'h04, 8'hFD); cyc(1'b1, 6'h08, 8'h02);
    chk("R4 pin1 driven high", 32'(po[1]), 1);
    cyc(1'b1, 6'h04, 8'hFF); cyc(1'b1, 6'h08, 8'h00);
    cyc(1'b1, 6'h04, 8'hFD);
    chk("R5 level kept across input write", 32'(po[1]), 1);
    cyc(1'b1, 6'h04, 8'hFF);
    pins[1] = 1'b1; idle(3);
    cyc(1'b0, 6'h08, 8'h00); chk("R5 input level read", 32'(rd), 32'h02);
    pins[1] = 1'b0; idle(3);

    // R6 latency, R7 rising only
    cyc(1'b1, 6'h0C, 8'h04); cyc(1'b1, 6'h14, 8'h04);
    pins[2] = 1'b1;
    cyc(1'b0, 6'h1C, 8'h00); chk("R6 edge A no status", 32'(sc[2]), 0);
    cyc(1'b0, 6'h1C, 8'h00); chk("R6 edge B no status", 32'(sc[2]), 0);
    cyc(1'b0, 6'h1C, 8'h00); chk("R6 edge C status", 32'(sc[2]), 1);
    chk("R6 irq", 32'(irq), 1);
    cyc(1'b1, 6'h1C, 8'h04); chk("R9 clear", 32'(sc), 0); chk("R9 irq drop", 32'(irq), 0);
    pins[2] = 1'b0; idle(4); chk("R7 rise-only ignores fall", 32'(sc[2]), 0);
    cyc(1'b1, 6'h0C, 8'h00); cyc(1'b1, 6'h10, 8'h04);
    pins[2] = 1'b1; idle(4); chk("R7 fall-only ignores rise", 32'(sc[2]), 0);
    pins[2] = 1'b0; idle(4); chk("R7 fall-only catches fall", 32'(sc[2]), 1);
    cyc(1'b1, 6'h1C, 8'h04);
    cyc(1'b1, 6'h0C, 8'h04);
    pins[2] = 1'b1; idle(4); chk("R7 both catches rise", 32'(sc[2]), 1);
    cyc(1'b1, 6'h1C, 8'h04);
    pins[2] = 1'b0; idle(4); chk("R7 both catches fall", 32'(sc[2]), 1);

    // R9 zero write and set-wins
    cyc(1'b1, 6'h1C, 8'hFB); chk("R9 zero write keeps", 32'(sc[2]), 1);
    pins[2] = 1'b1;
    cyc(1'b0, 6'h1C, 8'h00); cyc(1'b0, 6'h1C, 8'h00);
    cyc(1'b1, 6'h1C, 8'h04); chk("R9 set wins over clear", 32'(sc[2]), 1);
    cyc(1'b1, 6'h1C, 8'h04); chk("R9 later clear", 32'(sc[2]), 0);

    // R8 mask and enable
    cyc(1'b1, 6'h14, 8'h00);
    pins[2] = 1'b0; idle(4);
    chk("R8 status without mask", 32'(sc[2]), 1); chk("R8 masked irq", 32'(irq), 0);
    cyc(1'b1, 6'h14, 8'h04); chk("R10 mask raises irq", 32'(irq), 1);
    cyc(1'b1, 6'h1C, 8'h04); chk("R10 irq after clear", 32'(irq), 0);
    cyc(1'b1, 6'h00, 8'h02);
    pins[2] = 1'b1; idle(4); chk("R8 disabled no capture", 32'(sc[2]), 0);

    // R11 resume status word
    cyc(1'b1, 6'h20, 8'h03); cyc(1'b1, 6'h2C, 8'h02);
    pins[11] = 1'b1; idle(4);
    chk("R11 resume word", sr, 32'h2);
    cyc(1'b0, 6'h3C, 8'h00); chk("R11 resume status byte", 32'(rd), 32'h02);
    cyc(1'b1, 6'h3C, 8'h02); chk("R11 resume cleared", sr, 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 4) == 0) pins = NP'($urandom);
      cyc(($urandom % 2) == 1, 6'($urandom), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule